// File: doc/BRIEF.md
# Fractional Saturating Multiply-Accumulate Unit

This unit computes a multiply or a multiply-accumulate for a 32-bit core. It takes two word operands, an accumulator of up to two words, and a ten-bit opcode. It returns the result one clock after it accepts the operation. The opcode selects the result width (32, 48 or 64 bits) and whether an accumulator is added. It also selects integer or fractional (Q31/Q15) interpretation, signed or unsigned operands, and halfword operand selection, and it enables rounding and saturation.

Operations enter through a valid/ready input and leave through a valid/ready output that has a single result register. A new operation is accepted when the register is empty or is being drained in the same cycle, so the unit sustains one operation per clock. When the consumer holds `out_ready` low, the result stays frozen and the input stalls. There is no further buffering. A wide result is returned as a low/high word pair with a per-result overflow flag. A sticky saturation flag records that any accepted operation was clamped, and only reset clears it.

Top module: `frac_mac`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1, and its result is presented with `out_valid`=1 after that edge. `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_lo`, `out_hi` and `out_ovf` hold their values. Reset clears `out_valid`, the result and `sat_sticky`.
- R2: The fields of `in_op` are: width in bits [1:0] (00 = 32, 01 = 48, 10 or 11 = 64), accumulate in bit 2, fractional in bit 3, signed in bit 4, round in bit 5, saturate in bit 6, halfword in bit 7, A-upper-half in bit 8 and B-upper-half in bit 9. In halfword mode each operand is bits [31:16] if its half bit is 1 and bits [15:0] if it is 0.
- R3: In integer mode the exact result is acc + A*B. Operands are sign-extended when signed=1 and zero-extended when signed=0. When accumulate=0 the accumulator is taken as zero.
- R4: A 32-bit result drives `out_lo` with the low word and `out_hi` with zero. The accumulator for width 32 is `in_acc[31:0]`, sign-extended.
- R5: A 48-bit result wraps or clamps at 48 bits. `out_hi[31:16]` is the sign extension of bit 47. The accumulator for width 48 is `in_acc[47:0]`, sign-extended.
- R6: A 64-bit result drives `out_hi:out_lo` with the full value. The accumulator for width 64 is all of `in_acc`.
- R7: Fractional mode treats the operands as signed whatever the signed bit says, and it doubles the product. A halfword operand in fractional mode is placed in the upper half of a word (Q15 to Q31).
- R8: A fractional 32-bit result is the upper word of (acc<<32) + 2*A*B. When round=1, 2^31 is added before the upper word is taken. Round has no effect in any other mode.
- R9: A fractional product of the most negative operand with itself gives the largest positive value: 0x7FFFFFFF for 32-bit results and 0x7FFFFFFF_FFFFFFFF for 64-bit results. It sets `out_ovf` and sets `sat_sticky`, whether or not saturate is set.
- R10: With saturate=1, a result outside the signed range of the selected width is clamped to that width's signed maximum or minimum. `out_ovf` and `sat_sticky` are set.
- R11: With saturate=0, an out-of-range result wraps to the selected width. `out_ovf` is still set, but `sat_sticky` does not change.
- R12: Once set, `sat_sticky` stays 1 through later operations until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_acc | input | 64 | Accumulator, high word in [63:32] |
| in_op | input | 10 | Opcode fields (R2) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_lo | output | 32 | Low result word |
| out_hi | output | 32 | High result word |
| out_ovf | output | 1 | Result overflowed its width, or hit the fractional corner case |
| sat_sticky | output | 1 | Some accepted operation was saturated |

## Verification
The bench builds the unit with its default word width of 32. This gives 16-bit halves, a 48-bit middle width and a 64-bit pair, so every overflow edge and every fractional corner has a value that can be worked out by hand. These values include the most negative Q31 and Q15 squares, the rounding carry at bit 31 and the 48-bit wrap at 2^47. Each can be compared against an exact constant. A stalled consumer is held over several cycles while a second operation waits, which exercises both the frozen result and the blocked input.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    RW_32  = 2'b00,
    RW_48  = 2'b01,
    RW_64  = 2'b10,
    RW_64B = 2'b11
  } res_width_e;

  // opcode fields, most significant first (bit 9 down to bit 0)
  typedef struct packed {
    logic       b_upper;
    logic       a_upper;
    logic       halfword;
    logic       saturate;
    logic       round;
    logic       signed_op;
    logic       fractional;
    logic       accumulate;
    res_width_e width;
  } mac_op_t;

  localparam int OP_BITS = $bits(mac_op_t);

endpackage

// File: rtl/mac_opsel.sv
// Extends one source word to XLEN+1 signed bits, handling halfword choice
// and Q15-to-Q31 alignment for fractional halfword operations.
module mac_opsel #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]        src,
  input  logic                   halfword,
  input  logic                   upper,
  input  logic                   sgn,
  input  logic                   frac,
  output logic signed [XLEN:0]   val
);
  localparam int HW = XLEN / 2;

  logic [HW-1:0] half_val;

  always_comb begin
    half_val = upper ? src[XLEN-1:HW] : src[HW-1:0];
    if (!halfword)
      val = {sgn & src[XLEN-1], src};
    else if (frac)
      val = {half_val[HW-1], half_val, {HW{1'b0}}};
    else
      val = {{(HW+1){sgn & half_val[HW-1]}}, half_val};
  end
endmodule

// File: rtl/mac_mul.sv
// Signed multiply with fractional doubling and the min*min corner clamp.
module mac_mul #(
  parameter int XLEN = 32
) (
  input  logic signed [XLEN:0]       op_a,
  input  logic signed [XLEN:0]       op_b,
  input  logic                       frac,
  output logic signed [2*XLEN+1:0]   prod,
  output logic                       corner
);
  localparam int PW = 2 * XLEN + 2;
  localparam logic signed [XLEN:0]  OP_MIN = {2'b11, {(XLEN-1){1'b0}}};
  localparam logic signed [PW-1:0]  Q_MAX  = {3'b000, {(PW-3){1'b1}}};

  logic signed [PW-1:0] full;

  always_comb begin
    full   = op_a * op_b;
    corner = frac && (op_a == OP_MIN) && (op_b == OP_MIN);
    if (corner)
      prod = Q_MAX;
    else if (frac)
      prod = full <<< 1;
    else
      prod = full;
  end
endmodule

// File: rtl/mac_acc.sv
// Aligns the accumulator to the product, adds the rounding constant and
// returns the exact sum scaled to the selected result width.
module mac_acc #(
  parameter int XLEN = 32,
  localparam int SW  = 2 * XLEN + 4
) (
  input  logic [2*XLEN-1:0]           acc_in,
  input  logic signed [2*XLEN+1:0]    prod,
  input  mac_pkg::res_width_e         width,
  input  logic                        acc_en,
  input  logic                        frac,
  input  logic                        rnd,
  output logic signed [SW-1:0]        value
);
  import mac_pkg::*;

  localparam int MW = 3 * XLEN / 2;

  logic signed [SW-1:0] acc_ext;
  logic signed [SW-1:0] aligned;
  logic signed [SW-1:0] rnd_add;
  logic signed [SW-1:0] sum;
  logic                 q_upper;

  always_comb begin
    unique case (width)
      RW_32:   acc_ext = SW'($signed(acc_in[XLEN-1:0]));
      RW_48:   acc_ext = SW'($signed(acc_in[MW-1:0]));
      default: acc_ext = SW'($signed(acc_in));
    endcase
    if (!acc_en)
      acc_ext = '0;

    q_upper = frac && (width == RW_32);
    aligned = q_upper ? (acc_ext <<< XLEN) : acc_ext;
    rnd_add = '0;
    if (q_upper && rnd)
      rnd_add[XLEN-1] = 1'b1;

    sum   = aligned + SW'(prod) + rnd_add;
    value = q_upper ? (sum >>> XLEN) : sum;
  end
endmodule

// File: rtl/mac_sat.sv
// Range check against each width's signed limits, clamp or wrap, format.
module mac_sat #(
  parameter int XLEN = 32,
  localparam int SW  = 2 * XLEN + 4
) (
  input  logic signed [SW-1:0]   value,
  input  mac_pkg::res_width_e    width,
  input  logic                   sat_en,
  output logic [2*XLEN-1:0]      result,
  output logic                   out_of_range,
  output logic                   clamped
);
  import mac_pkg::*;

  localparam int NW = 3;
  localparam int MW = 3 * XLEN / 2;

  logic                 fit  [NW];
  logic signed [SW-1:0] lmax [NW];
  logic signed [SW-1:0] lmin [NW];

  for (genvar g = 0; g < NW; g++) begin : g_lim
    localparam int WG = (g == 0) ? XLEN : ((g == 1) ? MW : 2 * XLEN);
    localparam logic signed [SW-1:0] LMAX = {{(SW-WG+1){1'b0}}, {(WG-1){1'b1}}};
    localparam logic signed [SW-1:0] LMIN = {{(SW-WG+1){1'b1}}, {(WG-1){1'b0}}};
    assign lmax[g] = LMAX;
    assign lmin[g] = LMIN;
    assign fit[g]  = (value <= LMAX) && (value >= LMIN);
  end

  logic [1:0]           k;
  logic signed [SW-1:0] chosen;
  logic [SW-2*XLEN-1:0] unused_hi;

  always_comb begin
    unique case (width)
      RW_32:   k = 2'd0;
      RW_48:   k = 2'd1;
      default: k = 2'd2;
    endcase
    out_of_range = !fit[k];
    clamped      = out_of_range && sat_en;
    if (clamped)
      chosen = value[SW-1] ? lmin[k] : lmax[k];
    else
      chosen = value;
    unused_hi = chosen[SW-1:2*XLEN];
    unique case (k)
      2'd0:    result = {{XLEN{1'b0}}, chosen[XLEN-1:0]};
      2'd1:    result = {{(2*XLEN-MW){chosen[MW-1]}}, chosen[MW-1:0]};
      default: result = chosen[2*XLEN-1:0];
    endcase
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac #(
  parameter int XLEN = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [XLEN-1:0]       in_a,
  input  logic [XLEN-1:0]       in_b,
  input  logic [2*XLEN-1:0]     in_acc,
  input  logic [9:0]            in_op,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [XLEN-1:0]       out_lo,
  output logic [XLEN-1:0]       out_hi,
  output logic                  out_ovf,
  output logic                  sat_sticky
);
  import mac_pkg::*;

  localparam int SW = 2 * XLEN + 4;
  localparam int PW = 2 * XLEN + 2;

  mac_op_t op;
  assign op = mac_op_t'(in_op);

  // operand selection for A (index 0) and B (index 1)
  logic [XLEN-1:0]        src   [2];
  logic                   upper [2];
  logic signed [XLEN:0]   opv   [2];

  assign src[0]   = in_a;
  assign src[1]   = in_b;
  assign upper[0] = op.a_upper;
  assign upper[1] = op.b_upper;

  for (genvar i = 0; i < 2; i++) begin : g_opsel
    mac_opsel #(.XLEN(XLEN)) u_sel (
      .src      (src[i]),
      .halfword (op.halfword),
      .upper    (upper[i]),
      .sgn      (op.signed_op | op.fractional),
      .frac     (op.fractional),
      .val      (opv[i])
    );
  end

  logic signed [PW-1:0] prod;
  logic                 corner;

  mac_mul #(.XLEN(XLEN)) u_mul (
    .op_a   (opv[0]),
    .op_b   (opv[1]),
    .frac   (op.fractional),
    .prod   (prod),
    .corner (corner)
  );

  logic signed [SW-1:0] value;

  mac_acc #(.XLEN(XLEN)) u_acc (
    .acc_in (in_acc),
    .prod   (prod),
    .width  (op.width),
    .acc_en (op.accumulate),
    .frac   (op.fractional),
    .rnd    (op.round),
    .value  (value)
  );

  logic [2*XLEN-1:0] result;
  logic              out_of_range;
  logic              clamped;

  mac_sat #(.XLEN(XLEN)) u_sat (
    .value        (value),
    .width        (op.width),
    .sat_en       (op.saturate),
    .result       (result),
    .out_of_range (out_of_range),
    .clamped      (clamped)
  );

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_lo     <= '0;
      out_hi     <= '0;
      out_ovf    <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_lo    <= result[XLEN-1:0];
        out_hi    <= result[2*XLEN-1:XLEN];
        out_ovf   <= out_of_range | corner;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && (clamped || corner))
        sat_sticky <= 1'b1;
    end
  end
endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
  parameter int XLEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [9:0]       in_op,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  out_lo,
  input logic [XLEN-1:0]  out_hi,
  input logic             out_ovf,
  input logic             sat_sticky
);
  localparam logic [XLEN-1:0] W_MAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] W_MIN = {1'b1, {(XLEN-1){1'b0}}};

  // width and saturate bits of the operation now held in the result register
  logic [1:0] cap_w;
  logic       cap_sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_w   <= 2'b00;
      cap_sat <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_w   <= in_op[1:0];
      cap_sat <= in_op[6];
    end
  end

  a_r1_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r1_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lo) && $stable(out_hi) && $stable(out_ovf));

  a_r1_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r12_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky |=> sat_sticky);

  a_r4_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_w == 2'b00 |-> out_hi == '0);

  a_r5_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_w == 2'b01 |->
      ($countones(out_hi[XLEN-1:XLEN/2-1]) == 0) ||
      ($countones(out_hi[XLEN-1:XLEN/2-1]) == XLEN/2+1));

  a_r10_clamp_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_w == 2'b00 && cap_sat && out_ovf |-> (out_lo == W_MAX) || (out_lo == W_MIN));
endmodule

bind frac_mac frac_mac_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/frac_mac_bench.sv
`timescale 1ns/1ps
module frac_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [63:0] in_acc = '0;
  logic [9:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_lo, out_hi;
  logic        out_ovf, sat_sticky;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frac_mac u_frac_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_lo(out_lo),
    .out_hi(out_hi), .out_ovf(out_ovf), .sat_sticky(sat_sticky)
  );

  // field layout per R2
  function automatic logic [9:0] mkop(input logic [1:0] w, input bit ac, input bit fr,
                                      input bit sg, input bit rn, input bit st,
                                      input bit hf, input bit ah, input bit bh);
    return {bh, ah, hf, st, rn, sg, fr, ac, w};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // issue one operation with the consumer ready, then compare the result
  task automatic run_op(input string tag, input logic [9:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [63:0] acc,
                        input logic [31:0] e_lo, input logic [31:0] e_hi, input logic e_ovf);
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_acc = acc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, {out_hi, out_lo}, {e_hi, e_lo});
    check({tag, " ovf"}, {63'd0, out_ovf}, {63'd0, e_ovf});
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset sticky", {63'd0, sat_sticky}, 64'd0);
    check("R1 reset in_ready", {63'd0, in_ready}, 64'd1);
    check("R1 reset result", {out_hi, out_lo}, 64'd0);
  endtask

  task automatic t_integer();
    run_op("R3 R4 signed word", mkop(2'b00,0,0,1,0,0,0,0,0), 32'hFFFF_FFFD, 32'd7, 64'h0,
           32'hFFFF_FFEB, 32'h0, 1'b0);
    run_op("R3 R6 unsigned mac64", mkop(2'b10,1,0,0,0,0,0,0,0), 32'hFFFF_FFFF, 32'd2,
           64'h0000_0001_0000_0000, 32'hFFFF_FFFE, 32'h2, 1'b0);
    run_op("R3 acc ignored when off", mkop(2'b10,0,0,1,0,0,0,0,0), 32'd5, 32'd6,
           64'h1234_5678_9ABC_DEF0, 32'd30, 32'h0, 1'b0);
    run_op("R8 round no effect int", mkop(2'b00,0,0,1,1,0,0,0,0), 32'd3, 32'd4, 64'h0,
           32'd12, 32'h0, 1'b0);
  endtask

  task automatic t_halfword();
    run_op("R2 low A upper B", mkop(2'b00,0,0,1,0,0,1,0,1), 32'h8000_0003, 32'h0005_FFFF,
           64'h0, 32'd15, 32'h0, 1'b0);
    run_op("R2 signed upper A low B", mkop(2'b00,0,0,1,0,0,1,1,0), 32'h8000_0003,
           32'h0005_FFFF, 64'h0, 32'h0000_8000, 32'h0, 1'b0);
    run_op("R2 R3 unsigned halves", mkop(2'b00,0,0,0,0,0,1,1,0), 32'h8000_0003,
           32'h0005_FFFF, 64'h0, 32'h7FFF_8000, 32'h0, 1'b0);
  endtask

  task automatic t_width48();
    run_op("R5 negative sign extends", mkop(2'b01,0,0,1,0,0,0,0,0), 32'hFFFF_FFFF, 32'd5,
           64'h0, 32'hFFFF_FFFB, 32'hFFFF_FFFF, 1'b0);
    run_op("R5 R11 wrap at 48", mkop(2'b01,1,0,1,0,0,0,0,0), 32'd1, 32'd1,
           64'h0000_7FFF_FFFF_FFFF, 32'h0, 32'hFFFF_8000, 1'b1);
    check("R11 wrap leaves sticky", {63'd0, sat_sticky}, 64'd0);
    run_op("R5 R10 clamp at 48", mkop(2'b01,1,0,1,0,1,0,0,0), 32'd1, 32'd1,
           64'h0000_7FFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_7FFF, 1'b1);
    check("R10 clamp sets sticky", {63'd0, sat_sticky}, 64'd1);
  endtask

  task automatic t_sticky();
    run_op("R12 ordinary op", mkop(2'b00,0,0,1,0,0,0,0,0), 32'd2, 32'd2, 64'h0,
           32'd4, 32'h0, 1'b0);
    check("R12 sticky kept", {63'd0, sat_sticky}, 64'd1);
    do_reset();
    check("R12 reset clears sticky", {63'd0, sat_sticky}, 64'd0);
  endtask

  task automatic t_fractional();
    run_op("R7 R8 q31 half squared", mkop(2'b00,0,1,0,0,0,0,0,0), 32'h4000_0000,
           32'h4000_0000, 64'h0, 32'h2000_0000, 32'h0, 1'b0);
    run_op("R8 q31 mac", mkop(2'b00,1,1,0,0,0,0,0,0), 32'h4000_0000, 32'h4000_0000,
           64'h0000_0000_1000_0000, 32'h3000_0000, 32'h0, 1'b0);
    run_op("R7 q15 halves aligned", mkop(2'b00,0,1,0,0,0,1,0,0), 32'h0000_4000,
           32'h0000_4000, 64'h0, 32'h2000_0000, 32'h0, 1'b0);
  endtask

  task automatic t_round();
    run_op("R8 no round drops half", mkop(2'b00,0,1,1,0,0,0,0,0), 32'd1, 32'h4000_0000,
           64'h0, 32'd0, 32'h0, 1'b0);
    run_op("R8 round carries half", mkop(2'b00,0,1,1,1,0,0,0,0), 32'd1, 32'h4000_0000,
           64'h0, 32'd1, 32'h0, 1'b0);
    run_op("R8 round below half", mkop(2'b00,0,1,1,1,0,0,0,0), 32'd1, 32'h3FFF_FFFF,
           64'h0, 32'd0, 32'h0, 1'b0);
  endtask

  task automatic t_corner();
    do_reset();
    run_op("R9 q31 min squared", mkop(2'b00,0,1,1,0,0,0,0,0), 32'h8000_0000,
           32'h8000_0000, 64'h0, 32'h7FFF_FFFF, 32'h0, 1'b1);
    check("R9 corner sets sticky", {63'd0, sat_sticky}, 64'd1);
    run_op("R9 min squared 64", mkop(2'b10,0,1,0,0,0,0,0,0), 32'h8000_0000,
           32'h8000_0000, 64'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1);
    run_op("R9 q15 min squared", mkop(2'b00,0,1,0,0,0,1,1,1), 32'h8000_0000,
           32'h8000_0000, 64'h0, 32'h7FFF_FFFF, 32'h0, 1'b1);
  endtask

  task automatic t_saturate();
    do_reset();
    run_op("R11 word wraps", mkop(2'b00,0,0,1,0,0,0,0,0), 32'h7FFF_FFFF, 32'd2, 64'h0,
           32'hFFFF_FFFE, 32'h0, 1'b1);
    check("R11 sticky unchanged", {63'd0, sat_sticky}, 64'd0);
    run_op("R10 word clamps high", mkop(2'b00,0,0,1,0,1,0,0,0), 32'h7FFF_FFFF, 32'd2,
           64'h0, 32'h7FFF_FFFF, 32'h0, 1'b1);
    run_op("R10 word clamps low", mkop(2'b00,0,0,1,0,1,0,0,0), 32'h8000_0000, 32'd2,
           64'h0, 32'h8000_0000, 32'h0, 1'b1);
    run_op("R10 q31 mac clamps", mkop(2'b00,1,1,0,0,1,0,0,0), 32'h4000_0000,
           32'h4000_0000, 64'h0000_0000_7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 1'b1);
    check("R10 sticky set", {63'd0, sat_sticky}, 64'd1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_op = mkop(2'b00,0,0,1,0,0,0,0,0); in_a = 32'd2; in_b = 32'd3; in_valid = 1'b1;
    @(negedge clk);
    check("R1 stalled valid", {63'd0, out_valid}, 64'd1);
    check("R1 stalled not ready", {63'd0, in_ready}, 64'd0);
    check("R1 first result", {32'h0, out_lo}, 64'd6);
    in_a = 32'd4; in_b = 32'd5;
    @(negedge clk);
    check("R1 result held", {32'h0, out_lo}, 64'd6);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second accepted", {32'h0, out_lo}, 64'd20);
    check("R1 second valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R1 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_integer();
    t_halfword();
    t_width48();
    t_sticky();
    t_fractional();
    t_round();
    t_corner();
    t_saturate();
    t_backpressure();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule